// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a four-bit counter with two count strobes, one for counting up and one for counting down. A step in either direction needs a rising edge on its own strobe while the opposite strobe is held high. A build-time switch picks the modulus: decade (0 to 9) or binary (0 to 15). An active-low load copies a four-bit preset word into the count. An active-high clear forces the count to zero and wins over everything else.

Two active-low terminal flags make chaining possible. The carry flag is low while the count is at its top value and the up strobe is low. The borrow flag is low while the count is zero and the down strobe is low. Carry feeds the up strobe of the next stage and borrow feeds its down strobe, so stages connect with no glue logic. Both strobes are brought into one system clock through a synchronizer chain and then edge-detected. Load and clear take effect on the first system clock edge that samples them. In decade mode the counter leaves any code from 10 to 15 after a single count.

Top module: `dual_clk_counter`

## Requirements
- R1: When the up strobe rises while the down strobe is high, the count rises by one, and the top value wraps to 0. The count output changes on the third system clock rising edge after the strobe input changes.
- R2: When the down strobe rises while the up strobe is high, the count falls by one, and 0 wraps to the top value.
- R3: A strobe edge has no effect on the count while the opposite strobe is low.
- R4: While load_n_i is low, the count takes preset_i (bit 3 is the most significant bit). This wins over any count step.
- R5: While clear_i is high, the count becomes 0. This wins over load and over count steps.
- R6: carry_n_o is low exactly when the count equals the top value and the synchronized up strobe is low.
- R7: borrow_n_o is low exactly when the count is 0 and the synchronized down strobe is low.
- R8: The top value is 9 when DECADE is 1 and 15 when DECADE is 0.
- R9: In decade mode, an up step from any count of 10 to 15 gives 0, and a down step from such a count gives 9.
- R10: If both strobes show a rising edge on the same system clock cycle, the count does not change.
- R11: Each strobe is synchronized and produces at most one step per low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases synchronously |
| up_clk_i | input | 1 | Up count strobe |
| dn_clk_i | input | 1 | Down count strobe |
| load_n_i | input | 1 | Active-low parallel load |
| preset_i | input | WIDTH | Value to load |
| clear_i | input | 1 | Active-high clear; highest priority |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low carry flag |
| borrow_n_o | output | 1 | Active-low borrow flag |

## Verification
The bench builds two copies that share every input. One copy is built with DECADE=1 and the other with DECADE=0, both with the default width and synchronizer depth. Running them in lockstep makes each strobe pattern exercise both moduli at once.

The same preset then leads to different results in the two copies. Loading 12 or 13 is an illegal code in the decade copy, so it must recover, while the binary copy simply counts on. A walk through the full sequence reaches the wrap at 9 in one copy and the wrap at 15 in the other, and the carry and borrow flags are checked at each of those points.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;

  function automatic int unsigned top_value(input bit decade, input int unsigned width);
    return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
  endfunction
endpackage

// File: rtl/dcc_reset_sync.sv
module dcc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shr_q;
  logic [STAGES-1:0] shr_d;

  always_comb begin
    shr_d = {shr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shr_q <= '0;
    else        shr_q <= shr_d;
  end

  assign rst_sync_n = shr_q[STAGES-1];
endmodule

// File: rtl/dcc_edge_sync.sv
module dcc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign chain_d[g] = async_i;
    end else begin : g_rest
      assign chain_d[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;

  // R11
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dcc_count_core.sv
module dcc_count_core
  import dcc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] preset_i,
  input  step_e            step_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam int unsigned      TOP   = top_value(DECADE, WIDTH);
  localparam logic [WIDTH-1:0] TOP_V = WIDTH'(TOP);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (!load_n_i) begin
      cnt_en = 1'b1;
      cnt_d  = preset_i;
    end else begin
      case (step_i)
        STEP_UP: begin
          cnt_en = 1'b1;
          cnt_d  = (cnt_q >= TOP_V) ? '0 : cnt_q + WIDTH'(1);
        end
        STEP_DOWN: begin
          cnt_en = 1'b1;
          cnt_d  = ((cnt_q == '0) || (cnt_q > TOP_V)) ? TOP_V : cnt_q - WIDTH'(1);
        end
        default: begin
          cnt_en = 1'b0;
          cnt_d  = cnt_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));
  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n_i && !clear_i) |=> (cnt_q == $past(preset_i)));
  // R1
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_UP && !clear_i && load_n_i && cnt_q == TOP_V) |=> (cnt_q == '0));
  // R9
  illegal_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_UP && !clear_i && load_n_i && cnt_q > TOP_V) |=> (cnt_q == '0));
  // R9
  illegal_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_DOWN && !clear_i && load_n_i && cnt_q > TOP_V) |=> (cnt_q == TOP_V));
endmodule

// File: rtl/dcc_term_flags.sv
module dcc_term_flags
  import dcc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  localparam logic [WIDTH-1:0] TOP_V = WIDTH'(top_value(DECADE, WIDTH));

  always_comb begin
    carry_n_o  = ~((cnt_i == TOP_V) & ~up_lvl_i);
    borrow_n_o = ~((cnt_i == '0) & ~dn_lvl_i);
  end
endmodule

// File: rtl/dual_clk_counter.sv
module dual_clk_counter
  import dcc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_clk_i,
  input  logic             dn_clk_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             clear_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  localparam int               NSTROBE = 2;
  localparam int               UP_IDX  = 0;
  localparam int               DN_IDX  = 1;
  localparam logic [WIDTH-1:0] TOP_V   = WIDTH'(top_value(DECADE, WIDTH));

  logic               rst_sync_n;
  logic [NSTROBE-1:0] strobe_raw;
  logic [NSTROBE-1:0] strobe_lvl;
  logic [NSTROBE-1:0] strobe_rise;
  logic               up_ev;
  logic               dn_ev;
  step_e              step;

  dcc_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign strobe_raw = {dn_clk_i, up_clk_i};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_strobe
    dcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .async_i (strobe_raw[g]),
      .level_o (strobe_lvl[g]),
      .rise_o  (strobe_rise[g])
    );
  end

  always_comb begin
    up_ev = strobe_rise[UP_IDX] & strobe_lvl[DN_IDX];
    dn_ev = strobe_rise[DN_IDX] & strobe_lvl[UP_IDX];
    if (up_ev && !dn_ev)      step = STEP_UP;
    else if (dn_ev && !up_ev) step = STEP_DOWN;
    else                      step = STEP_HOLD;
  end

  dcc_count_core #(.WIDTH(WIDTH), .DECADE(DECADE)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear_i  (clear_i),
    .load_n_i (load_n_i),
    .preset_i (preset_i),
    .step_i   (step),
    .cnt_o    (count_o)
  );

  dcc_term_flags #(.WIDTH(WIDTH), .DECADE(DECADE)) u_flags (
    .cnt_i      (count_o),
    .up_lvl_i   (strobe_lvl[UP_IDX]),
    .dn_lvl_i   (strobe_lvl[DN_IDX]),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

  // R10
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_rise[UP_IDX] && strobe_rise[DN_IDX] && !clear_i && load_n_i) |=> $stable(count_o));
  // R3
  lone_up_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_rise[UP_IDX] && !strobe_lvl[DN_IDX] && !strobe_rise[DN_IDX] && !clear_i && load_n_i)
      |=> $stable(count_o));
  // R6
  carry_next_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!carry_n_o && !clear_i && load_n_i) |=> (count_o == TOP_V || count_o == '0));
  // R7
  borrow_next_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!borrow_n_o && !clear_i && load_n_i) |=> (count_o == '0 || count_o == TOP_V));
endmodule

// File: tb/sim_dual_clk_counter.sv
module sim_dual_clk_counter;
  localparam int CLK_P = 10;

  typedef struct {
    logic [3:0] cnt [2];
    logic       cy  [2];
    logic       bw  [2];
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up_clk = 1'b1;
  logic       dn_clk = 1'b1;
  logic       load_n = 1'b1;
  logic       clr = 1'b0;
  logic [3:0] pre = 4'd0;
  logic [3:0] cnt_o [2];
  logic       cy_o  [2];
  logic       bw_o  [2];

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t q [$];
  logic [3:0] cnt_m [2];
  logic       up_m = 1'b1;
  logic       dn_m = 1'b1;
  bit   done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dual_clk_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .up_clk_i(up_clk), .dn_clk_i(dn_clk),
    .load_n_i(load_n), .preset_i(pre), .clear_i(clr),
    .count_o(cnt_o[0]), .carry_n_o(cy_o[0]), .borrow_n_o(bw_o[0]));

  dual_clk_counter #(.WIDTH(4), .DECADE(1'b0), .SYNC_STAGES(2)) u1 (
    .clk(clk), .rst_n(rst_n), .up_clk_i(up_clk), .dn_clk_i(dn_clk),
    .load_n_i(load_n), .preset_i(pre), .clear_i(clr),
    .count_o(cnt_o[1]), .carry_n_o(cy_o[1]), .borrow_n_o(bw_o[1]));

  function automatic int top_of(input int i);
    return (i == 0) ? 9 : 15;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic up, input logic dn, input logic ldn,
                            input logic cl, input logic [3:0] pv, input string tag);
    exp_t e;
    logic upev;
    logic dnev;
    upev = up && !up_m && dn;
    dnev = dn && !dn_m && up;
    for (int i = 0; i < 2; i++) begin
      int mx;
      mx = top_of(i);
      if (cl)                cnt_m[i] = 4'd0;
      else if (!ldn)         cnt_m[i] = pv;
      else if (upev && !dnev) cnt_m[i] = (cnt_m[i] >= mx) ? 4'd0 : cnt_m[i] + 4'd1;
      else if (dnev && !upev) cnt_m[i] = (cnt_m[i] == 0 || cnt_m[i] > mx) ? 4'(mx) : cnt_m[i] - 4'd1;
      e.cnt[i] = cnt_m[i];
      e.cy[i]  = !(cnt_m[i] == mx && !up);
      e.bw[i]  = !(cnt_m[i] == 0 && !dn);
    end
    up_m  = up;
    dn_m  = dn;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic apply(input logic up, input logic dn, input logic ldn,
                       input logic cl, input logic [3:0] pv, input string tag);
    @(negedge clk);
    up_clk = up; dn_clk = dn; load_n = ldn; clr = cl; pre = pv;
    repeat (3) @(posedge clk);
    #1;
    model_step(up, dn, ldn, cl, pv, tag);
  endtask

  // monitor: pops expected items and compares them at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        for (int i = 0; i < 2; i++) begin
          check(e.tag, $sformatf("count[%0d]", i), int'(cnt_o[i]), int'(e.cnt[i]));
          check(e.tag, $sformatf("carry_n[%0d]", i), int'(cy_o[i]), int'(e.cy[i]));
          check(e.tag, $sformatf("borrow_n[%0d]", i), int'(bw_o[i]), int'(e.bw[i]));
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cnt_m[0] = 4'd0;
    cnt_m[1] = 4'd0;
    #(CLK_P * 2 + 1);
    check("R5", "reset count[0]", int'(cnt_o[0]), 0);
    check("R5", "reset count[1]", int'(cnt_o[1]), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    apply(1, 1, 1, 0, 0, "R10");

    // R1 R8 R6: ten up steps, decade wraps 9 -> 0, carry low at 9 with up low
    for (int k = 0; k < 10; k++) begin
      apply(0, 1, 1, 0, 0, "R6");
      apply(1, 1, 1, 0, 0, "R1");
    end
    // R5: clear
    apply(1, 1, 1, 1, 0, "R5");
    apply(1, 1, 1, 0, 0, "R5");
    // R2 R7: down from 0, borrow low then wrap to top
    apply(1, 0, 1, 0, 0, "R7");
    apply(1, 1, 1, 0, 0, "R2");
    apply(1, 0, 1, 0, 0, "R2");
    apply(1, 1, 1, 0, 0, "R2");
    // R9: illegal decade codes
    apply(1, 1, 0, 0, 4'd12, "R4");
    apply(1, 1, 1, 0, 4'd12, "R4");
    apply(0, 1, 1, 0, 0, "R9");
    apply(1, 1, 1, 0, 0, "R9");
    apply(1, 1, 0, 0, 4'd13, "R4");
    apply(1, 1, 1, 0, 4'd13, "R4");
    apply(1, 0, 1, 0, 0, "R9");
    apply(1, 1, 1, 0, 0, "R9");
    // R4: load wins over a simultaneous up edge
    apply(0, 1, 1, 0, 0, "R4");
    apply(1, 1, 0, 0, 4'd5, "R4");
    apply(1, 1, 1, 0, 4'd5, "R4");
    // R5: clear wins over load
    apply(1, 1, 0, 1, 4'd7, "R5");
    apply(1, 1, 1, 0, 4'd7, "R5");
    apply(1, 1, 0, 0, 4'd3, "R4");
    apply(1, 1, 1, 0, 4'd3, "R4");
    // R3: up edge while down low does nothing
    apply(1, 0, 1, 0, 0, "R3");
    apply(0, 0, 1, 0, 0, "R3");
    apply(1, 0, 1, 0, 0, "R3");
    apply(1, 1, 1, 0, 0, "R2");
    // R10: both edges together
    apply(0, 0, 1, 0, 0, "R10");
    apply(1, 1, 1, 0, 0, "R10");
    // R8: binary wrap 15 -> 0, decade illegal 15 -> 0
    apply(1, 1, 0, 0, 4'd15, "R8");
    apply(1, 1, 1, 0, 4'd15, "R8");
    apply(0, 1, 1, 0, 0, "R6");
    apply(1, 1, 1, 0, 0, "R8");
    // R11 R1: latency of one up step
    apply(0, 1, 1, 0, 0, "R11");
    @(negedge clk);
    up_clk = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R11", "count before third edge", int'(cnt_o[0]), int'(cnt_m[0]));
    @(posedge clk);
    #1;
    model_step(1, 1, 1, 0, 0, "R11");
    // R11: a held high strobe gives no further step
    apply(1, 1, 1, 0, 0, "R11");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule